// File: doc/BRIEF.md
# Parallel EEPROM Page Burst Writer

This block is the host side of a parallel EEPROM write. A single start command carries a page number and a byte count. The block then pulls that many bytes from a streaming source and writes each one with its own write-enable strobe. All bytes of the burst go to one page, at offsets that count up from zero. A byte must reach the memory before the device's load window closes. The block therefore keeps the gap between consecutive strobes inside a parameterised bound. If the source cannot keep up, the block stops accepting bytes.

After the last strobe the block releases the data bus. It then polls the last address it wrote. Each poll is a read with chip enable and output enable low. The bus is released again between polls. While the device is still programming, bit 7 of the read value is the inverse of the written value. When bit 7 matches what was written, the block reports completion. A poll budget that runs out produces a timeout instead. A byte count of zero, or one above the page size, is refused at once.

Top module: `eeprom_page_writer`

## Requirements
- R1: Write enable goes low only while chip enable is low, output enable is high and the block drives the data bus. Each low pulse lasts exactly STROBE_CYC clock cycles.
- R2: Every address issued during one burst carries the commanded page on bits 12..6. The strobes of a burst hit offsets 0, 1, 2 … in bits 5..0, in that order.
- R3: A burst of N bytes produces exactly N write strobes. The k-th strobe carries the k-th byte taken from the source.
- R4: Address and write data are already stable in the clock cycle before write enable falls. They stay unchanged, with chip enable low, in the cycle after it rises.
- R5: From one write-enable rise to the next fall takes at most WINDOW_CYC cycles. If the source has no byte by the last cycle that still meets this bound, the burst ends early. The block then polls the last byte written, and when that byte reads back true it raises err_stall for one cycle instead of done.
- R6: If start arrives with len equal to 0 or greater than 64, err_len pulses in the following cycle. No strobe is issued and busy stays low.
- R7: Polling begins only after a released-bus cycle. Each poll read has chip enable and output enable low and write enable high, targets the last written address, and is preceded by a cycle with chip enable high. done pulses once bit 7 of the read data equals bit 7 of the last written byte.
- R8: If no poll matches, err_timeout pulses exactly POLL_LIMIT+1 cycles after the last write-enable rise. Only one of done, err_stall, err_timeout and err_len is high in any cycle.
- R9: busy is high from the cycle after an accepted start until the cycle in which the result pulse appears. A start received while busy is ignored.
- R10: During reset chip enable, write enable and output enable are high, the data bus is released, and busy, src_ready and all result pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst (sampled only when idle) |
| page | input | 7 | Page number, becomes address bits 12..6 |
| len | input | 7 | Number of bytes in the burst, valid 1..64 |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block takes src_data on a cycle with src_valid high |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 13 | Memory address |
| mem_dq_o | output | 8 | Write data toward the memory |
| mem_dq_oe | output | 1 | High while the block drives the data bus |
| mem_dq_i | input | 8 | Read data from the memory |
| busy | output | 1 | Burst or polling in progress |
| done | output | 1 | One-cycle pulse, burst programmed |
| err_len | output | 1 | One-cycle pulse, byte count refused |
| err_stall | output | 1 | One-cycle pulse, source starved the load window |
| err_timeout | output | 1 | One-cycle pulse, polling budget exhausted |

## Verification
Bursts cover one byte, a full 64-byte page, and lengths in between. The source is driven back to back, with short gaps, and with gaps close to the window bound. This tells apart a correct strobe count and offset sequence from off-by-one pacing. A memory model that programs for zero, short or overlong times separates an immediate match on the first poll, a match after several polls, and exhaustion of the poll budget at its exact cycle. A source that stops mid-burst, refused counts of 0 and 65, and a start injected mid-burst test the early-termination, rejection and ignore paths.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int OFS_W      = 6,
  parameter int STROBE_CYC = 4,
  parameter int WINDOW_CYC = 14000,
  parameter int RD_CYC     = 2,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [ADDR_W-OFS_W-1:0]   page,
  input  logic [OFS_W:0]            len,
  input  logic                      src_valid,
  input  logic [DATA_W-1:0]         src_data,
  output logic                      src_ready,
  output logic                      mem_ce_n,
  output logic                      mem_we_n,
  output logic                      mem_oe_n,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_dq_o,
  output logic                      mem_dq_oe,
  input  logic [DATA_W-1:0]         mem_dq_i,
  output logic                      busy,
  output logic                      done,
  output logic                      err_len,
  output logic                      err_stall,
  output logic                      err_timeout
);

  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int TMAX   = (STROBE_CYC > RD_CYC) ? STROBE_CYC : RD_CYC;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int GW     = $clog2(WINDOW_CYC + 1);
  localparam int PW     = $clog2(POLL_LIMIT + 1);
  localparam logic [OFS_W:0]  MAX_LEN   = (OFS_W+1)'(1 << OFS_W);
  localparam logic [TW-1:0]   STB_LAST  = TW'(STROBE_CYC - 1);
  localparam logic [TW-1:0]   RD_LAST   = TW'(RD_CYC - 1);
  localparam logic [GW-1:0]   GAP_LAST  = GW'(WINDOW_CYC - 3);
  localparam logic [PW-1:0]   POLL_LAST = PW'(POLL_LIMIT - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_SETUP, S_STROBE, S_HOLD, S_PGAP, S_PRD
  } state_t;

  state_t             st;
  logic [PAGE_W-1:0]  page_q;
  logic [OFS_W:0]     len_q;
  logic [OFS_W:0]     idx;
  logic [OFS_W-1:0]   ofs_q;
  logic [DATA_W-1:0]  data_q;
  logic [TW-1:0]      tmr;
  logic [GW-1:0]      gap;
  logic [PW-1:0]      poll;
  logic               stalled;

  wire len_bad = (len == '0) || (len > MAX_LEN);
  wire hit     = mem_dq_i[DATA_W-1] == data_q[DATA_W-1];
  wire wr_bus  = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);

  assign busy      = st != S_IDLE;
  assign src_ready = st == S_WAIT;
  assign mem_we_n  = st != S_STROBE;
  assign mem_oe_n  = st != S_PRD;
  assign mem_ce_n  = !(wr_bus || st == S_PRD);
  assign mem_dq_oe = wr_bus;
  assign mem_dq_o  = data_q;
  assign mem_addr  = {page_q, ofs_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      page_q <= '0;
      len_q <= '0;
      idx <= '0;
      ofs_q <= '0;
      data_q <= '0;
      tmr <= '0;
      gap <= '0;
      poll <= '0;
      stalled <= 1'b0;
      done <= 1'b0;
      err_len <= 1'b0;
      err_stall <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      err_len <= 1'b0;
      err_stall <= 1'b0;
      err_timeout <= 1'b0;
      unique case (st)
        S_IDLE:
          if (start) begin
            if (len_bad) begin
              err_len <= 1'b1;
            end else begin
              page_q <= page;
              len_q <= len;
              idx <= '0;
              gap <= '0;
              stalled <= 1'b0;
              st <= S_WAIT;
            end
          end
        S_WAIT:
          if (src_valid) begin
            data_q <= src_data;
            ofs_q <= idx[OFS_W-1:0];
            st <= S_SETUP;
          end else if (idx != '0 && gap == GAP_LAST) begin
            stalled <= 1'b1;
            poll <= '0;
            st <= S_PGAP;
          end else if (idx != '0) begin
            gap <= gap + 1'b1;
          end
        S_SETUP: begin
          tmr <= '0;
          st <= S_STROBE;
        end
        S_STROBE:
          if (tmr == STB_LAST) begin
            idx <= idx + 1'b1;
            st <= S_HOLD;
          end else begin
            tmr <= tmr + 1'b1;
          end
        S_HOLD:
          if (idx == len_q) begin
            poll <= '0;
            st <= S_PGAP;
          end else begin
            gap <= '0;
            st <= S_WAIT;
          end
        S_PGAP: begin
          poll <= poll + 1'b1;
          tmr <= '0;
          if (poll == POLL_LAST) begin
            err_timeout <= 1'b1;
            st <= S_IDLE;
          end else begin
            st <= S_PRD;
          end
        end
        S_PRD: begin
          poll <= poll + 1'b1;
          tmr <= tmr + 1'b1;
          if (tmr == RD_LAST && hit) begin
            if (stalled) err_stall <= 1'b1;
            else         done <= 1'b1;
            st <= S_IDLE;
          end else if (poll == POLL_LAST) begin
            err_timeout <= 1'b1;
            st <= S_IDLE;
          end else if (tmr == RD_LAST) begin
            st <= S_PGAP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_we_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W]));

  p_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_o) && !$past(mem_ce_n)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_o) && !mem_ce_n));

  p_len_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && len_bad) |=> (err_len && !busy && mem_we_n));

  p_poll_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n && !mem_dq_oe));

  p_poll_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(mem_ce_n));

  p_one_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_len, err_stall, err_timeout}));

endmodule

// File: tb/eeprom_page_writer_tb_top.sv
module eeprom_page_writer_tb_top;
  localparam int STROBE = 3;
  localparam int WIN    = 40;
  localparam int RDC    = 2;
  localparam int PLIM   = 200;

  typedef struct packed {
    logic [6:0]  pg;
    logic [6:0]  n;
    logic [15:0] prog;
    logic [7:0]  dly;
    logic [6:0]  stall_at;
    logic [1:0]  res;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'h00, 7'd1,  16'd30,  8'd0,  7'd0, 2'd0},
    '{7'h7F, 7'd64, 16'd50,  8'd0,  7'd0, 2'd0},
    '{7'h2A, 7'd5,  16'd0,   8'd3,  7'd0, 2'd0},
    '{7'h13, 7'd17, 16'd120, 8'd20, 7'd0, 2'd0},
    '{7'h55, 7'd9,  16'd500, 8'd1,  7'd0, 2'd2},
    '{7'h06, 7'd10, 16'd40,  8'd2,  7'd3, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [6:0] page = '0;
  logic [6:0] len = '0;
  logic src_valid = 1'b0;
  logic [7:0] src_data = '0;
  logic src_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [12:0] mem_addr;
  logic [7:0] mem_dq_o, mem_dq_i;
  logic busy, done, err_len, err_stall, err_timeout;

  always #5 clk = ~clk;

  eeprom_page_writer #(
    .STROBE_CYC(STROBE), .WINDOW_CYC(WIN), .RD_CYC(RDC), .POLL_LIMIT(PLIM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .page(page), .len(len),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .busy(busy), .done(done), .err_len(err_len),
    .err_stall(err_stall), .err_timeout(err_timeout)
  );

  function automatic logic [7:0] pat(input logic [6:0] pg, input int i);
    return 8'(int'(pg) * 37 + i * 91) ^ 8'h5C;
  endfunction

  int n_checks = 0, n_errs = 0;
  int mon_checks = 0, mon_errs = 0;
  logic [6:0] exp_page = '0;
  int burst_base = 0;
  int prog_cyc = 0;

  int cyc = 0, we_total = 0, n_outcome = 0, last_res = 0, to_gap = 0;
  int rise_cyc = 0, fall_cyc = 0, busy_cnt = 0;
  logic [7:0] pagebuf [64];
  logic [7:0] last_data = '0;
  logic [12:0] last_addr = '0;
  logic p_we = 1'b1, p_oe = 1'b1, p_ce = 1'b1;
  logic [12:0] p_addr = '0;
  logic [7:0] p_dq = '0;

  always_comb begin
    if (!mem_ce_n && !mem_oe_n)
      mem_dq_i = (busy_cnt > 0) ? {~last_data[7], last_data[6:0]} : pagebuf[mem_addr[5:0]];
    else
      mem_dq_i = 8'h00;
  end

  task automatic mcheck(input bit ok, input string tag, input int act, input int exp);
    mon_checks++;
    if (!ok) begin
      mon_errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (p_we && !mem_we_n) begin
        mcheck(mem_addr == p_addr && mem_dq_o == p_dq, "R4 setup", int'(mem_addr), int'(p_addr));
        mcheck(!mem_ce_n && mem_oe_n && mem_dq_oe, "R1 strobe gating", int'({mem_ce_n, mem_oe_n, mem_dq_oe}), 3'b011);
        mcheck(mem_addr[12:6] == exp_page, "R2 page bits", int'(mem_addr[12:6]), int'(exp_page));
        mcheck(int'(mem_addr[5:0]) == we_total - burst_base, "R2 offset order", int'(mem_addr[5:0]), we_total - burst_base);
        if (we_total != burst_base)
          mcheck(cyc - rise_cyc <= WIN, "R5 load window", cyc - rise_cyc, WIN);
        fall_cyc = cyc;
      end
      if (!p_we && mem_we_n) begin
        mcheck(mem_addr == p_addr && mem_dq_o == p_dq && !mem_ce_n, "R4 hold", int'(mem_addr), int'(p_addr));
        mcheck(cyc - fall_cyc == STROBE, "R1 strobe width", cyc - fall_cyc, STROBE);
        mcheck(p_dq == pat(exp_page, we_total - burst_base), "R3 byte order", int'(p_dq), int'(pat(exp_page, we_total - burst_base)));
        pagebuf[p_addr[5:0]] = p_dq;
        last_data = p_dq;
        last_addr = p_addr;
        busy_cnt = prog_cyc;
        we_total = we_total + 1;
        rise_cyc = cyc;
      end
      if (p_oe && !mem_oe_n) begin
        mcheck(p_ce, "R7 bus released before poll", int'(p_ce), 1);
        mcheck(mem_addr == last_addr, "R7 poll address", int'(mem_addr), int'(last_addr));
        mcheck(mem_we_n && !mem_dq_oe, "R7 poll strobes", int'({mem_we_n, mem_dq_oe}), 2'b10);
      end
      if (done || err_stall || err_timeout || err_len) begin
        last_res = done ? 0 : err_stall ? 1 : err_timeout ? 2 : 3;
        to_gap = cyc - rise_cyc;
        n_outcome = n_outcome + 1;
      end
      if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    end
    p_we = mem_we_n;
    p_oe = mem_oe_n;
    p_ce = mem_ce_n;
    p_addr = mem_addr;
    p_dq = mem_dq_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_burst(input logic [6:0] pg, input logic [6:0] n, input int prog,
                           input int dly, input int stall_at, input int res);
    int n0, w0, feed;
    feed = (stall_at != 0) ? stall_at : int'(n);
    @(negedge clk);
    exp_page = pg;
    burst_base = we_total;
    prog_cyc = prog;
    n0 = n_outcome;
    w0 = we_total;
    start = 1'b1;
    page = pg;
    len = n;
    fork
      begin
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
      end
      begin
        for (int i = 0; i < feed; i++) begin
          repeat (dly) @(negedge clk);
          src_data = pat(pg, i);
          src_valid = 1'b1;
          while (!src_ready) @(negedge clk);
          @(negedge clk);
          src_valid = 1'b0;
        end
      end
    join
    wait (n_outcome != n0);
    @(negedge clk);
    check(last_res == res, "R5/R7/R8 result kind", last_res, res);
    check(we_total - w0 == feed, "R3 strobe count", we_total - w0, feed);
    check(busy == 1'b0, "R9 idle after result", int'(busy), 0);
    if (res == 2) check(to_gap == PLIM + 1, "R8 timeout latency", to_gap, PLIM + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog (all requirements): actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks + mon_checks + 1, n_errs + mon_errs + 1);
    $finish;
  end

  initial begin
    int w0, n0;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n, "R10 reset strobes", int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
    check(!mem_dq_oe && !busy && !src_ready, "R10 reset bus/busy", int'({mem_dq_oe, busy, src_ready}), 0);
    check(!done && !err_len && !err_stall && !err_timeout, "R10 reset results", int'({done, err_len, err_stall, err_timeout}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 6; v++)
      run_burst(VECS[v].pg, VECS[v].n, int'(VECS[v].prog), int'(VECS[v].dly),
                int'(VECS[v].stall_at), int'(VECS[v].res));

    foreach (len_bad_vals[k]) begin end

    for (int k = 0; k < 2; k++) begin
      w0 = we_total;
      start = 1'b1;
      page = 7'h33;
      len = (k == 0) ? 7'd0 : 7'd65;
      @(negedge clk);
      start = 1'b0;
      check(err_len == 1'b1, "R6 bad length flagged", int'(err_len), 1);
      check(busy == 1'b0, "R6 stays idle", int'(busy), 0);
      repeat (10) @(negedge clk);
      check(we_total == w0, "R6 no strobes", we_total - w0, 0);
    end

    n0 = n_outcome;
    fork
      run_burst(7'h4C, 7'd12, 40, 2, 0, 0);
      begin
        repeat (20) @(negedge clk);
        check(busy == 1'b1, "R9 busy mid-burst", int'(busy), 1);
        start = 1'b1;
        page = 7'h11;
        len = 7'd2;
        @(negedge clk);
        start = 1'b0;
      end
    join
    repeat (20) @(negedge clk);
    check(n_outcome == n0 + 1, "R9 start while busy ignored", n_outcome - n0, 1);
    check(busy == 1'b0, "R9 no second burst", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks + mon_checks, n_errs + mon_errs);
    $finish;
  end

  logic [1:0] len_bad_vals [2];

endmodule